// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Serial Shift Register

This block is an eight-stage parallel-in, serial-out shift register built entirely inside one system-clock domain. A level-sensitive, active-low load strobe copies a parallel word into the stages. While the strobe is held low, the stages keep following the parallel inputs, and no shift can take place. When the strobe is high, the register shifts once for every rising edge of the OR of two slow clock pins. The serial input enters the lowest stage, and the highest stage drives the serial output and its complement.

The two clock pins, like the load strobe, come from outside the system domain. Each pin passes through a multi-flop synchroniser. An edge detector turns the rising edge of the combined clock into a one-cycle shift strobe. Either clock pin can serve as the shifting clock. Holding the other pin high forces the combined clock high, which freezes the register, so a high pin works as an active-low enable. The enable may only be raised while the other clock is already high. Otherwise that rise would itself be a combined-clock edge and cause a shift.

Top module: `dual_clk_piso`

## Requirements
- R1: While `load_n` is low, every stage n takes `par_in[n]` on every system clock. A change on `load_n` takes effect at the third rising `sys_clk` edge after it is driven.
- R2: While the synchronised `load_n` is low, no shift occurs, whatever the clock pins do.
- R3: With load inactive, each rising edge of (`clk_a` OR `clk_b`) causes exactly one shift, at the third `sys_clk` edge after the pin rises. On a shift, stage 0 takes `ser_in` and stage n takes the old stage n-1.
- R4: `ser_out` always equals stage 7 (the highest stage), and `ser_out_n` always equals its complement.
- R5: While one clock pin is held high, activity on the other pin causes no shift, and a falling combined clock causes no shift.
- R6: After a load, `par_in[7]` appears on `ser_out` first, followed by bits 6 down to 0 on successive shifts.
- R7: A synchronous active-high `sys_rst` clears all stages to 0. No shift occurs after reset is released if the clock pins are already high.
- R8: When load is active and a shift strobe arrives on the same system edge, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| clk_a | input | 1 | First shift clock pin (asynchronous) |
| clk_b | input | 1 | Second shift clock pin (asynchronous) |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel data, bit n into stage n |
| ser_out | output | 1 | Highest stage |
| ser_out_n | output | 1 | Complement of the highest stage |

## Verification
The bound checker examines every system cycle. It confirms that the outputs are complementary and that the stages follow the parallel word while load is active, including when a strobe arrives on the same edge. It also confirms that a strobe moves the stages by exactly one position and that the stages stay unchanged when neither load nor strobe is present. Only the bench scenarios can show the pin-level behaviour. These include the three-edge latency through the synchronisers, the order of bits after a load, that each clock pin drives shifts on its own, that a high pin holds the register, and that a load arriving in the middle of a shift sequence wins.

// File: rtl/piso_pkg.sv
package piso_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2
   } piso_op_e;

   // load beats a strobe arriving on the same system edge
   function automatic piso_op_e pick_op(input logic load_act, input logic shift_stb);
      if (load_act)
         return OP_LOAD;
      else if (shift_stb)
         return OP_SHIFT;
      else
         return OP_HOLD;
   endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int          N       = 1,
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   logic [N-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("pin_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= {N{RST_VAL}};
      else     chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[s] <= {N{RST_VAL}};
         else     chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clk_edge_det.sv
module clk_edge_det #(
   parameter int NCLK = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NCLK-1:0] pins_s,
   output logic            shift_stb
);
   logic comb_now;
   logic comb_prev;

   assign comb_now = |pins_s;

   always_ff @(posedge clk) begin
      if (rst) comb_prev <= 1'b1;
      else     comb_prev <= comb_now;
   end

   assign shift_stb = comb_now & ~comb_prev;
endmodule

// File: rtl/piso_core.sv
module piso_core
   import piso_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_act,
   input  logic             shift_stb,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] stage_q
);
   piso_op_e op;
   assign op = pick_op(load_act, shift_stb);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic shift_src;
      if (i == 0) begin : g_head
         assign shift_src = ser_in;
      end else begin : g_body
         assign shift_src = stage_q[i-1];
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            stage_q[i] <= 1'b0;
         end else begin
            case (op)
               OP_LOAD:  stage_q[i] <= par_in[i];
               OP_SHIFT: stage_q[i] <= shift_src;
               default:  stage_q[i] <= stage_q[i];
            endcase
         end
      end
   end
endmodule

// File: rtl/dual_clk_piso.sv
module dual_clk_piso #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             sys_clk,
   input  logic             sys_rst,
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             load_n,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic             ser_out,
   output logic             ser_out_n
);
   localparam int NCLK = 2;
   localparam int MSB  = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("dual_clk_piso: WIDTH must be at least 2");
   end

   logic [NCLK-1:0]  pins_s;
   logic             load_n_s;
   logic             load_act;
   logic             shift_stb;
   logic [WIDTH-1:0] stage_q;

   pin_sync #(.N(NCLK), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clk_sync (
      .clk (sys_clk),
      .rst (sys_rst),
      .d   ({clk_b, clk_a}),
      .q   (pins_s)
   );

   pin_sync #(.N(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_load_sync (
      .clk (sys_clk),
      .rst (sys_rst),
      .d   (load_n),
      .q   (load_n_s)
   );

   assign load_act = ~load_n_s;

   clk_edge_det #(.NCLK(NCLK)) u_edge (
      .clk       (sys_clk),
      .rst       (sys_rst),
      .pins_s    (pins_s),
      .shift_stb (shift_stb)
   );

   piso_core #(.WIDTH(WIDTH)) u_core (
      .clk       (sys_clk),
      .rst       (sys_rst),
      .load_act  (load_act),
      .shift_stb (shift_stb),
      .ser_in    (ser_in),
      .par_in    (par_in),
      .stage_q   (stage_q)
   );

   assign ser_out   = stage_q[MSB];
   assign ser_out_n = ~stage_q[MSB];
endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
   parameter int WIDTH = 8
) (
   input logic             sys_clk,
   input logic             sys_rst,
   input logic             ser_in,
   input logic [WIDTH-1:0] par_in,
   input logic             ser_out,
   input logic             ser_out_n,
   input logic             load_act,
   input logic             shift_stb,
   input logic [WIDTH-1:0] stages
);
   logic rst_q;
   always @(posedge sys_clk) rst_q <= sys_rst;

   // R7: first cycle out of reset sees cleared stages
   always @(posedge sys_clk) begin
      if (rst_q === 1'b1 && sys_rst === 1'b0)
         a_reset_clear_r7: assert (stages == '0)
            else $error("stages not cleared after reset");
   end

   p_compl_r4: assert property (@(posedge sys_clk) disable iff (sys_rst)
      ser_out_n == ~ser_out);

   p_top_r4: assert property (@(posedge sys_clk) disable iff (sys_rst)
      ser_out == stages[WIDTH-1]);

   p_load_copy_r1: assert property (@(posedge sys_clk) disable iff (sys_rst)
      load_act |=> stages == $past(par_in));

   p_load_wins_r8: assert property (@(posedge sys_clk) disable iff (sys_rst)
      (load_act && shift_stb) |=> stages == $past(par_in));

   p_shift_step_r3: assert property (@(posedge sys_clk) disable iff (sys_rst)
      (!load_act && shift_stb) |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});

   p_idle_hold_r5: assert property (@(posedge sys_clk) disable iff (sys_rst)
      (!load_act && !shift_stb) |=> $stable(stages));

   p_single_stb_r3: assert property (@(posedge sys_clk) disable iff (sys_rst)
      shift_stb |=> !shift_stb);
endmodule

bind dual_clk_piso piso_checker #(.WIDTH(WIDTH)) u_chk (
   .sys_clk   (sys_clk),
   .sys_rst   (sys_rst),
   .ser_in    (ser_in),
   .par_in    (par_in),
   .ser_out   (ser_out),
   .ser_out_n (ser_out_n),
   .load_act  (load_act),
   .shift_stb (shift_stb),
   .stages    (stage_q)
);

// File: tb/dual_clk_piso_test.sv
`timescale 1ns/1ps
module dual_clk_piso_test;
   logic       sys_clk = 1'b0;
   logic       sys_rst = 1'b1;
   logic       clk_a   = 1'b0;
   logic       clk_b   = 1'b0;
   logic       load_n  = 1'b1;
   logic       ser_in  = 1'b0;
   logic [7:0] par_in  = 8'h00;
   logic       ser_out;
   logic       ser_out_n;

   int tests  = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 sys_clk = ~sys_clk;   // 250 MHz

   dual_clk_piso uut (
      .sys_clk (sys_clk), .sys_rst (sys_rst),
      .clk_a (clk_a), .clk_b (clk_b), .load_n (load_n),
      .ser_in (ser_in), .par_in (par_in),
      .ser_out (ser_out), .ser_out_n (ser_out_n)
   );

   // behavioural reference: pin histories kept in queues
   bit [7:0] m_q;
   bit       or_hist[$];
   bit       ld_hist[$];

   always @(posedge sys_clk) begin
      if (sys_rst) begin
         m_q = 8'h00;
         or_hist = '{1'b1, 1'b1, 1'b1};   // [0]=3 edges ago
         ld_hist = '{1'b1, 1'b1};         // [0]=2 edges ago
      end else begin
         if (!ld_hist[0])                          m_q = par_in;
         else if (or_hist[1] && !or_hist[0])       m_q = {m_q[6:0], ser_in};
         void'(or_hist.pop_front());
         void'(ld_hist.pop_front());
         or_hist.push_back(clk_a | clk_b);
         ld_hist.push_back(load_n);
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R3 R4)
   always @(negedge sys_clk) begin
      if (!sys_rst && !done) begin
         check("R3 model", ser_out, m_q[7]);
         check("R4 complement", ser_out_n, ~m_q[7]);
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge sys_clk);
   endtask

   task automatic pulse_a();
      clk_a = 1'b1; wait_cyc(4);
      clk_a = 1'b0; wait_cyc(4);
   endtask

   task automatic pulse_b();
      clk_b = 1'b1; wait_cyc(4);
      clk_b = 1'b0; wait_cyc(4);
   endtask

   task automatic do_load(input logic [7:0] v);
      par_in = v; load_n = 1'b0; wait_cyc(5);
      load_n = 1'b1; wait_cyc(4);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge sys_clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] pat;
      // R7: reset with clocks high, then release: cleared, no false shift
      clk_a = 1'b1; ser_in = 1'b1;
      wait_cyc(4);
      check("R7 reset clear", ser_out, 1'b0);
      sys_rst = 1'b0;
      wait_cyc(6);
      check("R7 no shift after reset", ser_out, 1'b0);
      clk_a = 1'b0; wait_cyc(4);

      // R1 latency: drive load low, effect at the third edge
      par_in = 8'h80;
      @(negedge sys_clk) load_n = 1'b0;
      wait_cyc(2);
      check("R1 not yet loaded", ser_out, 1'b0);
      wait_cyc(1);
      check("R1 loaded at third edge", ser_out, 1'b1);
      // R1: stages follow parallel inputs while load held
      par_in = 8'h00; wait_cyc(2);
      check("R1 follows par_in", ser_out, 1'b0);
      load_n = 1'b1; wait_cyc(4);

      // R6 + R3: load A5, shift out with clk_a alone
      pat = 8'hA5; ser_in = 1'b0;
      do_load(pat);
      check("R6 first bit is P7", ser_out, pat[7]);
      for (int k = 1; k < 8; k++) begin
         pulse_a();
         check("R6 bit order", ser_out, pat[7-k]);
      end
      pulse_a();
      check("R3 serial in reaches top", ser_out, 1'b0);

      // R3 with clk_b alone, ser_in = 1 fills register
      ser_in = 1'b1;
      for (int k = 0; k < 8; k++) pulse_b();
      check("R3 clk_b fills ones", ser_out, 1'b1);

      // R5: clk_a high holds while clk_b toggles
      pat = 8'h5A; ser_in = 1'b0;
      do_load(pat);
      clk_a = 1'b1; wait_cyc(4);             // one shift from clk_a rising
      check("R3 shift on enable rise", ser_out, pat[6]);
      clk_b = 1'b1; wait_cyc(4);             // clk_b rises while clk_a high
      for (int k = 0; k < 3; k++) pulse_b();
      check("R5 hold with clk_a high", ser_out, pat[6]);
      clk_b = 1'b0; wait_cyc(4);
      clk_a = 1'b0; wait_cyc(4);             // falling combined clock
      check("R5 no shift on fall", ser_out, pat[6]);
      pulse_a();
      check("R5 contents kept", ser_out, pat[5]);

      // R2 + R8: load asserted during shift sequence
      pat = 8'h3C;
      par_in = pat; load_n = 1'b0;
      pulse_a(); pulse_b();
      check("R2 no shift under load", ser_out, pat[7]);
      load_n = 1'b1; wait_cyc(4);
      pulse_a();
      check("R8 load kept", ser_out, pat[6]);
      pulse_a();
      check("R8 load kept next", ser_out, pat[5]);

      // R8: load and edge reach the core on the same edge
      pat = 8'hC3;
      par_in = pat;
      @(negedge sys_clk); load_n = 1'b0; clk_a = 1'b1;
      wait_cyc(4);
      load_n = 1'b1; wait_cyc(4);
      check("R8 load wins over strobe", ser_out, pat[7]);
      clk_a = 1'b0; wait_cyc(4);

      finish_run();
   end
endmodule